// File: doc/BRIEF.md
# Flash Identification Readout Unit

This unit produces the identification replies of a serial flash device. An SPI front-end decodes the opcode and passes it in with a one-cycle strobe. It also delivers each later byte from the host with a byte strobe, and it gives one strobe for each output bit time, on the falling edge of the serial clock. The unit answers three query types. The first is a fixed multi-byte JEDEC identity string. The second is a single device signature, which follows a run of dummy bytes and repeats for as long as the host keeps clocking. The third is a manufacturer/device pair: an address byte picks which ID comes first, and the two IDs then alternate without end.

The output is one bit with a separate enable. When the enable is low, the pin is high-impedance. Raising chip select ends any reply at once. Queries are refused while a program or erase operation runs. In deep power-down, only the signature and pair queries are served. A signature query that has delivered at least one whole byte raises a one-cycle request to leave deep power-down when chip select rises.

Top module: `idr_id_readout`

## Requirements
- R1: `so_oe` is low out of reset, while `cs_n` is high, and while dummy or address bytes are being collected.
- R2: Opcode 9Fh returns the bytes C2h, 20h, 15h in that order, MSB first, with one bit advanced per `shift_stb`.
- R3: After the third byte of the 9Fh reply, `so_oe` stays low until `cs_n` rises, whatever `shift_stb` does.
- R4: Opcode ABh, followed by three bytes on `rx_valid`, returns the byte 14h.
- R5: The ABh reply repeats 14h on every following byte time until `cs_n` rises.
- R6: Opcode 90h is followed by two dummy bytes and one address byte. Bit 0 of the address byte chooses the first ID: 0 gives C2h, 1 gives 14h. The other address bits have no effect.
- R7: After the first ID of a 90h reply, the output alternates between C2h and 14h on each following byte.
- R8: Raising `cs_n` at any point, including in the middle of a byte, ends the reply. The next command then starts from its first bit.
- R9: A command strobed while `busy` is high is ignored, and `so_oe` stays low.
- R10: While `deep_pd` is high, 9Fh is ignored, but ABh and 90h are served normally.
- R11: `wake_req` pulses for exactly one cycle, in the cycle after `cs_n` is seen high. It does so only if an ABh reply had shifted out at least one whole byte.
- R12: While a reply is active, `so_bit` changes only after a cycle in which `shift_stb` was high.
- R13: Any opcode other than 9Fh, ABh and 90h is ignored, and `so_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select from the front-end, active low |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_op` holds a decoded opcode |
| cmd_op | input | 8 | Decoded opcode |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a byte received after the opcode |
| rx_byte | input | 8 | Received dummy or address byte |
| busy | input | 1 | Program or erase operation in progress |
| deep_pd | input | 1 | Device is in deep power-down |
| shift_stb | input | 1 | One-cycle strobe per output bit time (serial clock falling edge) |
| so_bit | output | 1 | Current output bit, MSB first |
| so_oe | output | 1 | Output enable; low means the pin is high-impedance |
| wake_req | output | 1 | One-cycle request to leave deep power-down |

## Verification
The assertions make several assumptions about the inputs:
- `cmd_valid` arrives only while `cs_n` is low.
- `rx_valid` and `shift_stb` never arrive in the same cycle as `cmd_valid`.
- Each query is given its own chip-select window.
- The front-end never strobes `shift_stb` before the dummy and address bytes are complete.

The bench drives every input from negative-edge tasks that keep each strobe to one cycle. It opens a fresh chip-select window for every query, and it fires bit strobes only after the argument bytes are done. This keeps all stimulus, including the 256-value address and opcode sweeps, inside those assumptions.

// File: rtl/idr_pkg.sv
package idr_pkg;
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ARGS,
      PH_SHIFT,
      PH_DONE
   } idr_phase_e;

   typedef enum logic [1:0] {
      MD_NONE,
      MD_JEDEC,
      MD_SIG,
      MD_PAIR
   } idr_mode_e;
endpackage

// File: rtl/idr_cmd_track.sv
module idr_cmd_track
   import idr_pkg::*;
#(
   parameter logic [7:0] OP_JEDEC   = 8'h9F,
   parameter logic [7:0] OP_SIG     = 8'hAB,
   parameter logic [7:0] OP_PAIR    = 8'h90,
   parameter int         SIG_DUMMY  = 3,
   parameter int         PAIR_DUMMY = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_op,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       busy,
   input  logic       deep_pd,
   input  logic       byte_done,
   input  logic       last_byte,
   output idr_phase_e phase,
   output idr_mode_e  mode,
   output logic       dev_first
);
   localparam int ARG_MAX = (SIG_DUMMY > PAIR_DUMMY + 1) ? SIG_DUMMY : PAIR_DUMMY + 1;
   localparam int CNT_W   = (ARG_MAX > 1) ? $clog2(ARG_MAX) : 1;
   localparam logic [CNT_W-1:0] SIG_LAST  = CNT_W'(SIG_DUMMY - 1);
   localparam logic [CNT_W-1:0] PAIR_LAST = CNT_W'(PAIR_DUMMY);

   logic [CNT_W-1:0] arg_cnt;
   logic [CNT_W-1:0] arg_last;
   idr_mode_e        req_mode;
   logic             unused_addr_hi;

   assign unused_addr_hi = ^rx_byte[7:1];
   assign arg_last       = (mode == MD_SIG) ? SIG_LAST : PAIR_LAST;

   always_comb begin
      req_mode = MD_NONE;
      if (cmd_valid && !cs_n && !busy && phase == PH_IDLE) begin
         if (cmd_op == OP_JEDEC && !deep_pd) req_mode = MD_JEDEC;
         else if (cmd_op == OP_SIG)          req_mode = MD_SIG;
         else if (cmd_op == OP_PAIR)         req_mode = MD_PAIR;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         mode      <= MD_NONE;
         arg_cnt   <= '0;
         dev_first <= 1'b0;
      end else if (cs_n) begin
         phase   <= PH_IDLE;
         mode    <= MD_NONE;
         arg_cnt <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (req_mode != MD_NONE) begin
                  mode    <= req_mode;
                  arg_cnt <= '0;
                  phase   <= (req_mode == MD_JEDEC) ? PH_SHIFT : PH_ARGS;
               end
            end
            PH_ARGS: begin
               if (rx_valid) begin
                  if (arg_cnt == arg_last) begin
                     phase <= PH_SHIFT;
                     if (mode == MD_PAIR) dev_first <= rx_byte[0];
                  end else begin
                     arg_cnt <= arg_cnt + CNT_W'(1);
                  end
               end
            end
            PH_SHIFT: begin
               if (byte_done && mode == MD_JEDEC && last_byte) phase <= PH_DONE;
            end
            default: phase <= phase;
         endcase
      end
   end

   AST_CS_ENDS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> phase == PH_IDLE); // R8
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && busy) |=> phase == PH_IDLE); // R9
   AST_PD_BLOCKS_JEDEC: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && deep_pd && cmd_op == OP_JEDEC) |=> phase == PH_IDLE); // R10
   AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && cmd_op != OP_JEDEC && cmd_op != OP_SIG && cmd_op != OP_PAIR)
      |=> phase == PH_IDLE); // R13
endmodule

// File: rtl/idr_bit_shift.sv
module idr_bit_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              shift_stb,
   output logic [$clog2(BYTE_W)-1:0] bit_idx,
   output logic              byte_done
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

   assign byte_done = active && shift_stb && (bit_idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         bit_idx <= IDX_TOP;
      end else if (shift_stb) begin
         bit_idx <= (bit_idx == '0) ? IDX_TOP : bit_idx - IDX_W'(1);
      end
   end

   AST_IDX_STEPS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !shift_stb) |=> (!active || $stable(bit_idx))); // R12
endmodule

// File: rtl/idr_byte_sel.sv
module idr_byte_sel
   import idr_pkg::*;
#(
   parameter int                      JEDEC_LEN = 3,
   parameter logic [8*JEDEC_LEN-1:0]  JEDEC_ID  = 24'hC22015,
   parameter logic [7:0]              MFR_ID    = 8'hC2,
   parameter logic [7:0]              DEV_ID    = 8'h14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       byte_done,
   input  idr_mode_e  mode,
   input  logic       dev_first,
   output logic [7:0] cur_byte,
   output logic       last_byte,
   output logic       seen
);
   localparam int CNT_W = (JEDEC_LEN > 1) ? $clog2(JEDEC_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JEDEC_LEN - 1);

   logic [7:0]       jed_tab [JEDEC_LEN];
   logic [CNT_W-1:0] byte_cnt;
   logic             alt;

   for (genvar g = 0; g < JEDEC_LEN; g++) begin : g_jed
      assign jed_tab[g] = JEDEC_ID[8*(JEDEC_LEN-1-g) +: 8];
   end

   assign last_byte = (byte_cnt == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         byte_cnt <= '0;
         alt      <= 1'b0;
         seen     <= 1'b0;
      end else if (byte_done) begin
         byte_cnt <= last_byte ? byte_cnt : byte_cnt + CNT_W'(1);
         alt      <= ~alt;
         seen     <= 1'b1;
      end
   end

   always_comb begin
      case (mode)
         MD_JEDEC: cur_byte = jed_tab[byte_cnt];
         MD_SIG:   cur_byte = DEV_ID;
         MD_PAIR:  cur_byte = (alt ^ dev_first) ? DEV_ID : MFR_ID;
         default:  cur_byte = 8'h00;
      endcase
   end

   AST_PAIR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && mode == MD_PAIR) |=> (!active || cur_byte != $past(cur_byte))); // R7
   AST_SIG_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode == MD_SIG) |-> cur_byte == DEV_ID); // R5
endmodule

// File: rtl/idr_id_readout.sv
module idr_id_readout
   import idr_pkg::*;
#(
   parameter logic [7:0]             OP_JEDEC   = 8'h9F,
   parameter logic [7:0]             OP_SIG     = 8'hAB,
   parameter logic [7:0]             OP_PAIR    = 8'h90,
   parameter int                     SIG_DUMMY  = 3,
   parameter int                     PAIR_DUMMY = 2,
   parameter int                     JEDEC_LEN  = 3,
   parameter logic [8*JEDEC_LEN-1:0] JEDEC_ID   = 24'hC22015,
   parameter logic [7:0]             MFR_ID     = 8'hC2,
   parameter logic [7:0]             DEV_ID     = 8'h14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_op,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       busy,
   input  logic       deep_pd,
   input  logic       shift_stb,
   output logic       so_bit,
   output logic       so_oe,
   output logic       wake_req
);
   localparam int BYTE_W = 8;
   localparam int IDX_W  = $clog2(BYTE_W);

   if (SIG_DUMMY < 1) begin : g_chk_sig
      $fatal(1, "SIG_DUMMY must be at least 1");
   end
   if (PAIR_DUMMY < 0) begin : g_chk_pair
      $fatal(1, "PAIR_DUMMY must not be negative");
   end
   if (JEDEC_LEN < 1) begin : g_chk_len
      $fatal(1, "JEDEC_LEN must be at least 1");
   end
   if (MFR_ID == DEV_ID) begin : g_chk_ids
      $fatal(1, "MFR_ID and DEV_ID must differ for alternation to be visible");
   end

   idr_phase_e       phase;
   idr_mode_e        mode;
   logic             dev_first;
   logic             active;
   logic [IDX_W-1:0] bit_idx;
   logic             byte_done;
   logic [7:0]       cur_byte;
   logic             last_byte;
   logic             seen;

   assign active = (phase == PH_SHIFT) && !cs_n;
   assign so_oe  = active;
   assign so_bit = active && cur_byte[bit_idx];

   idr_cmd_track #(
      .OP_JEDEC  (OP_JEDEC),
      .OP_SIG    (OP_SIG),
      .OP_PAIR   (OP_PAIR),
      .SIG_DUMMY (SIG_DUMMY),
      .PAIR_DUMMY(PAIR_DUMMY)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .busy     (busy),
      .deep_pd  (deep_pd),
      .byte_done(byte_done),
      .last_byte(last_byte),
      .phase    (phase),
      .mode     (mode),
      .dev_first(dev_first)
   );

   idr_bit_shift #(
      .BYTE_W(BYTE_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .shift_stb(shift_stb),
      .bit_idx  (bit_idx),
      .byte_done(byte_done)
   );

   idr_byte_sel #(
      .JEDEC_LEN(JEDEC_LEN),
      .JEDEC_ID (JEDEC_ID),
      .MFR_ID   (MFR_ID),
      .DEV_ID   (DEV_ID)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .byte_done(byte_done),
      .mode     (mode),
      .dev_first(dev_first),
      .cur_byte (cur_byte),
      .last_byte(last_byte),
      .seen     (seen)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) wake_req <= 1'b0;
      else        wake_req <= cs_n && phase == PH_SHIFT && mode == MD_SIG && seen;
   end

   AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$past(shift_stb)) |-> $stable(so_bit)); // R12
   AST_WAKE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(cs_n)); // R11
   AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req); // R11
   AST_QUIET_IN_ARGS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ARGS) |-> !so_oe); // R1
endmodule

// File: tb/tb_idr_id_readout.sv
module tb_idr_id_readout;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] EXP_MFR  = 8'hC2;
   localparam logic [7:0] EXP_TYPE = 8'h20;
   localparam logic [7:0] EXP_DENS = 8'h15;
   localparam logic [7:0] EXP_DEV  = 8'h14;

   logic clk = 1'b0;
   logic rst_n, cs_n, cmd_valid, rx_valid, busy, deep_pd, shift_stb;
   logic [7:0] cmd_op, rx_byte;
   logic so_bit, so_oe, wake_req;
   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idr_id_readout dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy), .deep_pd(deep_pd),
      .shift_stb(shift_stb), .so_bit(so_bit), .so_oe(so_oe), .wake_req(wake_req)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cs_begin();
      cs_n = 1'b0;
      @(negedge clk);
   endtask

   task automatic cs_end(output logic w1, output logic w2);
      cs_n = 1'b1;
      @(negedge clk);
      w1 = wake_req;
      @(negedge clk);
      w2 = wake_req;
   endtask

   task automatic send_cmd(input logic [7:0] op);
      cmd_valid = 1'b1;
      cmd_op    = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic send_rx(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic read_bits(input int n, output logic [7:0] b, output logic oe_ok);
      b = 8'h00;
      oe_ok = 1'b1;
      for (int i = 0; i < n; i++) begin
         b = {b[6:0], so_bit};
         if (!so_oe) oe_ok = 1'b0;
         shift_stb = 1'b1;
         @(negedge clk);
         shift_stb = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] b;
      logic oe_ok, w1, w2, hold_v;
      logic [7:0] jexp [3];
      jexp[0] = EXP_MFR; jexp[1] = EXP_TYPE; jexp[2] = EXP_DENS;
      rst_n = 1'b0; cs_n = 1'b1; cmd_valid = 1'b0; cmd_op = 8'h00;
      rx_valid = 1'b0; rx_byte = 8'h00; busy = 1'b0; deep_pd = 1'b0; shift_stb = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(so_oe == 1'b0, "R1 reset oe", so_oe, 0);
      check(wake_req == 1'b0, "R11 reset wake", wake_req, 0);

      // R2 R3 R12: JEDEC reply, bit held without strobes
      cs_begin();
      send_cmd(8'h9F);
      hold_v = so_bit;
      repeat (3) @(negedge clk);
      check(so_bit == hold_v, "R12 bit hold", so_bit, hold_v);
      for (int k = 0; k < 3; k++) begin
         read_bits(8, b, oe_ok);
         check(b == jexp[k], "R2 jedec byte", b, jexp[k]);
         check(oe_ok, "R2 jedec oe", oe_ok, 1);
      end
      check(so_oe == 1'b0, "R3 after jedec", so_oe, 0);
      read_bits(8, b, oe_ok);
      check(so_oe == 1'b0, "R3 strobes after jedec", so_oe, 0);
      cs_end(w1, w2);
      check(w1 == 1'b0, "R11 no wake on jedec", w1, 0);
      check(so_oe == 1'b0, "R1 cs high", so_oe, 0);

      // R4 R5 R11: signature repeats, wake after full byte
      cs_begin();
      send_cmd(8'hAB);
      for (int k = 0; k < 3; k++) begin
         check(so_oe == 1'b0, "R1 oe during dummies", so_oe, 0);
         send_rx(8'h5A);
      end
      for (int k = 0; k < 4; k++) begin
         read_bits(8, b, oe_ok);
         check(b == EXP_DEV, k == 0 ? "R4 signature" : "R5 signature repeat", b, EXP_DEV);
         check(oe_ok, "R4 oe", oe_ok, 1);
      end
      cs_end(w1, w2);
      check(w1 == 1'b1, "R11 wake pulse", w1, 1);
      check(w2 == 1'b0, "R11 wake single", w2, 0);

      // R11: partial signature byte gives no wake
      cs_begin();
      send_cmd(8'hAB);
      for (int k = 0; k < 3; k++) send_rx(8'h00);
      read_bits(5, b, oe_ok);
      cs_end(w1, w2);
      check(w1 == 1'b0 && w2 == 1'b0, "R11 partial no wake", w1, 0);

      // R6 R7: address sweep over all 256 values
      for (int a = 0; a < 256; a++) begin
         cs_begin();
         send_cmd(8'h90);
         send_rx(8'hFF);
         send_rx(8'h00);
         send_rx(8'(a));
         for (int k = 0; k < 3; k++) begin
            logic [7:0] e;
            e = ((a % 2) ^ (k % 2)) ? EXP_DEV : EXP_MFR;
            read_bits(8, b, oe_ok);
            check(b == e && oe_ok, k == 0 ? "R6 pair first id" : "R7 pair alternate", b, e);
         end
         cs_end(w1, w2);
         if (a == 1) check(w1 == 1'b0, "R11 no wake on pair", w1, 0);
      end

      // R8: abort mid-byte, restart from the first bit
      cs_begin();
      send_cmd(8'h9F);
      read_bits(3, b, oe_ok);
      cs_end(w1, w2);
      check(so_oe == 1'b0, "R8 abort oe", so_oe, 0);
      cs_begin();
      send_cmd(8'h9F);
      read_bits(8, b, oe_ok);
      check(b == EXP_MFR, "R8 restart first byte", b, EXP_MFR);
      cs_end(w1, w2);

      // R9: busy blocks commands
      busy = 1'b1;
      cs_begin();
      send_cmd(8'hAB);
      for (int k = 0; k < 3; k++) send_rx(8'h00);
      read_bits(8, b, oe_ok);
      check(so_oe == 1'b0, "R9 busy ignored", so_oe, 0);
      cs_end(w1, w2);
      check(w1 == 1'b0, "R9 busy no wake", w1, 0);
      busy = 1'b0;

      // R10: deep power-down filtering
      deep_pd = 1'b1;
      cs_begin();
      send_cmd(8'h9F);
      check(so_oe == 1'b0, "R10 jedec ignored in pd", so_oe, 0);
      cs_end(w1, w2);
      cs_begin();
      send_cmd(8'hAB);
      for (int k = 0; k < 3; k++) send_rx(8'h00);
      read_bits(8, b, oe_ok);
      check(b == EXP_DEV && oe_ok, "R10 signature in pd", b, EXP_DEV);
      cs_end(w1, w2);
      check(w1 == 1'b1, "R11 wake from pd", w1, 1);
      cs_begin();
      send_cmd(8'h90);
      for (int k = 0; k < 3; k++) send_rx(8'h00);
      read_bits(8, b, oe_ok);
      check(b == EXP_MFR && oe_ok, "R10 pair in pd", b, EXP_MFR);
      cs_end(w1, w2);
      deep_pd = 1'b0;

      // R13: every other opcode is ignored
      for (int op = 0; op < 256; op++) begin
         if (op == 'h9F || op == 'hAB || op == 'h90) continue;
         cs_begin();
         send_cmd(8'(op));
         send_rx(8'h00); send_rx(8'h00); send_rx(8'h00);
         check(so_oe == 1'b0, "R13 unknown opcode", so_oe, 0);
         cs_end(w1, w2);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule